// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the digital side of a small serial EEPROM that answers a three-wire bus made of a select line, a serial clock and a data-in line, with one data-out line driven back. The bus pins are brought into the system clock domain through short synchronisers. A command starts with a 1 bit. Then come a two-bit command code, an address and, for the two data-carrying commands, a data word. The block decodes seven commands: word read, word write, word erase, fill-all, clear-all, enable-programming and disable-programming. Reads stream out words from the behavioural array for as long as the select line is held high.

Programming commands are gated by an enable latch and a write-protect input. Each one runs as a self-timed operation of a fixed number of system clocks. It starts when the select line falls after the last command bit and, once started, it always completes. While it runs, raising the select line shows the progress on the data-out line. A width input picks 16-bit words or 8-bit bytes, and this sets both the address length and the data length.

Top module: `sereep_slave`

## Requirements
- R1: After reset the output enable and the output data are 0, programming is disabled and every array bit reads as 1. Whenever no read or status output is active, both outputs stay 0.
- R2: While select is high, serial-clock rising edges with data-in 0 are ignored until a 1 arrives. That 1 is the start bit. It is followed, MSB first, by a 2-bit code: 10 read, 01 write, 11 erase, 00 extended. Then comes the address: AW16 = log2(WORDS16) bits in 16-bit mode, AW16+1 bits in 8-bit mode. For an extended command the two top address bits select the action: 11 enable, 00 disable, 01 fill-all, 10 clear-all. The lower address bits are ignored.
- R3: After the last address bit of a read, the output enable goes to 1 and the data output shows one 0 bit. On each later serial-clock rising edge it shows the next bit of the addressed word or byte, MSB first.
- R4: With select still high after a read, the next word follows straight away with no extra 0 bit. The address steps by one and wraps from the last location to 0.
- R5: Only the enable command sets the programming latch, and only the disable command clears it. While the latch is clear, write, erase, fill-all and clear-all change nothing. Reads work in both states.
- R6: While the write-protect input is low, no programming command changes the array.
- R7: An accepted programming command starts when select falls after its last bit, and it stays busy for PROG_CYCLES system clocks. While the status indication is armed and select is high, the output enable is 1 and the data output is 0 while busy, then 1 once finished.
- R8: A serial-clock rising edge with select high and data-in 1 disarms the status indication, and the output enable then drops.
- R9: Erase sets every bit of one location to 1. Clear-all sets every bit of the array to 1.
- R10: A write leaves the location equal to the new data whatever it held before. Fill-all writes the data to every location (both bytes of each word in 16-bit mode).
- R11: Commands that arrive while a programming operation runs are ignored, including enable and disable.
- R12: In 8-bit mode address b selects byte b. In 16-bit mode word w is formed from byte 2w+1 (bits 15:8) and byte 2w (bits 7:0).
- R13: A command whose select line falls before its last bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Bus select, high selects the device |
| sclk_i | input | 1 | Serial bus clock, bits taken on its rising edge |
| sdin_i | input | 1 | Serial data in |
| wprot_n_i | input | 1 | Write protect, low blocks programming |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| sdout_o | output | 1 | Serial data out (read data or busy/ready) |
| sdout_oe_o | output | 1 | Output enable for sdout_o |

## Verification
Reads are run as full-array sweeps in both widths and as short runs that cross the top address. These separate the address stepping and wrap from plain single-word access. The written patterns are chosen so that some bits go from 1 to 0 and others from 0 to 1, which separates a real erase-before-write from an AND or OR merge. The patterns are also unequal between bytes, which exposes any swap in the byte-to-word mapping. Programming is tried with the latch clear, with write protect low, with a command cut short and with commands sent during busy, and each of these must leave the array as it was.

// File: rtl/sereep_pkg.sv
// Shared codes and types for the serial EEPROM slave.
package sereep_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_READ, ST_DONE} dec_state_t;
    typedef enum logic [1:0] {PG_WORD, PG_ERASE, PG_FILL, PG_CLEAR} prog_kind_t;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] EXT_EN    = 2'b11;
    localparam logic [1:0] EXT_DIS   = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
endpackage

// File: rtl/sereep_sync.sv
// Brings the three bus inputs into the clk domain through two flops each.
// It gives a serial-clock rise pulse and a select fall pulse. Assumes the bus
// runs several times slower than clk, so no edge is ever missed.
module sereep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    output logic sel_s,
    output logic sdin_s,
    output logic sclk_rise,
    output logic sel_fall
);
    logic [2:0] sel_p;
    logic [2:0] sclk_p;
    logic [1:0] sdin_p;

    // Synchroniser chains plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_p  <= '0;
            sclk_p <= '0;
            sdin_p <= '0;
        end else begin
            sel_p  <= {sel_p[1:0], sel_i};
            sclk_p <= {sclk_p[1:0], sclk_i};
            sdin_p <= {sdin_p[0], sdin_i};
        end
    end

    assign sel_s     = sel_p[1];
    assign sdin_s    = sdin_p[1];
    assign sclk_rise = sclk_p[1] & ~sclk_p[2];
    assign sel_fall  = ~sel_p[1] & sel_p[2];
endmodule

// File: rtl/sereep_array.sv
// Behavioural byte array with a self-timed programming engine.
// A start pulse erases the target at once (erase before write). After
// PROG_CYCLES clocks the final contents are committed and busy drops.
// The read port is combinational. Assumes start is never given while busy.
module sereep_array import sereep_pkg::*; #(
    parameter int BYTES       = 32,
    parameter int PROG_CYCLES = 400,
    localparam int AW8        = $clog2(BYTES),
    localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  prog_kind_t     kind,
    input  logic [AW8-1:0] addr,
    input  logic [15:0]    data,
    input  logic           wide,
    input  logic [AW8-1:0] rd_addr,
    output logic [15:0]    rd_word,
    output logic           busy
);
    logic [7:0]     mem [BYTES];
    logic [CW-1:0]  cnt_q;
    prog_kind_t     kind_q;
    logic [AW8-1:0] lo_q, hi_q;
    logic [15:0]    data_q;
    logic           wide_q;
    logic [AW8-1:0] lo_idx, hi_idx;

    // Byte indices of the target location for both widths.
    always_comb begin
        lo_idx = wide ? {addr[AW8-2:0], 1'b0} : addr;
        hi_idx = wide ? {addr[AW8-2:0], 1'b1} : addr;
    end

    // Programming sequencer and array storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
            busy   <= 1'b0;
            cnt_q  <= '0;
            kind_q <= PG_WORD;
            lo_q   <= '0;
            hi_q   <= '0;
            data_q <= '0;
            wide_q <= 1'b0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= CW'(PROG_CYCLES - 1);
            kind_q <= kind;
            lo_q   <= lo_idx;
            hi_q   <= hi_idx;
            data_q <= data;
            wide_q <= wide;
            if (kind == PG_WORD || kind == PG_ERASE) begin
                mem[lo_idx] <= 8'hFF;
                mem[hi_idx] <= 8'hFF;
            end
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
                case (kind_q)
                    PG_WORD: begin
                        mem[lo_q] <= data_q[7:0];
                        if (wide_q) mem[hi_q] <= data_q[15:8];
                    end
                    PG_FILL:
                        for (int i = 0; i < BYTES; i++)
                            mem[i] <= (wide_q && (i % 2 == 1)) ? data_q[15:8] : data_q[7:0];
                    PG_CLEAR:
                        for (int i = 0; i < BYTES; i++) mem[i] <= 8'hFF;
                    default: ;
                endcase
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Read port, left-aligned: a byte sits in bits 15:8.
    always_comb begin
        if (wide) rd_word = {mem[{rd_addr[AW8-2:0], 1'b1}], mem[{rd_addr[AW8-2:0], 1'b0}]};
        else      rd_word = {mem[rd_addr], 8'h00};
    end
endmodule

// File: rtl/sereep_slave.sv
// Serial EEPROM slave top. It frames commands after a start bit, decodes
// them, streams read data, keeps the programming enable latch and shows
// busy/ready. Assumes wide_i and wprot_n_i are quasi-static and that
// WORDS16 is a power of two, at least 4.
module sereep_slave import sereep_pkg::*; #(
    parameter int WORDS16     = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdin_i,
    input  logic wprot_n_i,
    input  logic wide_i,
    output logic sdout_o,
    output logic sdout_oe_o
);
    localparam int BYTES = 2 * WORDS16;
    localparam int AW8   = $clog2(BYTES);
    localparam int AW16  = AW8 - 1;
    localparam int CNTW  = $clog2(2 + AW8 + 16 + 1);
    localparam logic [AW8-1:0] MASK16 = {1'b0, {AW16{1'b1}}};
    localparam logic [AW8-1:0] MASK8  = '1;

    logic sel_s, sdin_s, sk_rise, sel_fall, sk_evt;
    logic busy, prog_start, in_read;
    logic [15:0] rd_word;

    dec_state_t     state_q;
    logic [CNTW-1:0] bit_cnt_q;
    logic [1:0]     op_q;
    logic [AW8-1:0] addr_q;
    logic [15:0]    data_q;
    logic           pend_q, wen_q, stat_q, do_q;
    prog_kind_t     pend_kind_q;
    logic [15:0]    rd_sh_q;
    logic [4:0]     rd_left_q;

    logic [AW8-1:0] mask, addr_shift, addr_inc, rd_port_addr;
    logic [1:0]     top2;
    logic [CNTW-1:0] addr_end, data_end;
    logic [4:0]     dw_n;

    sereep_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sclk_i(sclk_i), .sdin_i(sdin_i),
        .sel_s(sel_s), .sdin_s(sdin_s), .sclk_rise(sk_rise), .sel_fall(sel_fall)
    );

    // Frame geometry and address arithmetic for the selected width.
    always_comb begin
        mask       = wide_i ? MASK16 : MASK8;
        addr_shift = {addr_q[AW8-2:0], sdin_s} & mask;
        addr_inc   = (addr_q + AW8'(1)) & mask;
        top2       = wide_i ? addr_shift[AW16-1 -: 2] : addr_shift[AW8-1 -: 2];
        addr_end   = wide_i ? CNTW'(2 + AW16) : CNTW'(2 + AW8);
        dw_n       = wide_i ? 5'd16 : 5'd8;
        data_end   = addr_end + CNTW'(dw_n);
        rd_port_addr = (state_q == ST_READ) ? addr_inc : addr_shift;
    end

    assign sk_evt     = sk_rise & sel_s;
    assign in_read    = (state_q == ST_READ);
    assign prog_start = sel_fall && (state_q == ST_DONE) && pend_q && wen_q && wprot_n_i && !busy;

    // Command framing, decode, read streaming and status arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bit_cnt_q   <= '0;
            op_q        <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            pend_q      <= 1'b0;
            pend_kind_q <= PG_WORD;
            wen_q       <= 1'b0;
            stat_q      <= 1'b0;
            do_q        <= 1'b0;
            rd_sh_q     <= '0;
            rd_left_q   <= '0;
        end else if (sel_fall) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            if (prog_start) stat_q <= 1'b1;
        end else if (sk_evt) begin
            case (state_q)
                ST_IDLE: if (sdin_s) begin
                    stat_q <= 1'b0;
                    if (!busy) begin
                        state_q   <= ST_SHIFT;
                        bit_cnt_q <= '0;
                        op_q      <= '0;
                        addr_q    <= '0;
                        data_q    <= '0;
                        pend_q    <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (bit_cnt_q < CNTW'(2))   op_q   <= {op_q[0], sdin_s};
                    else if (bit_cnt_q < addr_end) addr_q <= addr_shift;
                    else                           data_q <= {data_q[14:0], sdin_s};
                    if (bit_cnt_q + 1'b1 == addr_end) begin
                        case (op_q)
                            OPC_READ: begin
                                state_q   <= ST_READ;
                                do_q      <= 1'b0;
                                rd_sh_q   <= rd_word;
                                rd_left_q <= dw_n;
                            end
                            OPC_WRITE: ;
                            OPC_ERASE: begin
                                state_q     <= ST_DONE;
                                pend_q      <= 1'b1;
                                pend_kind_q <= PG_ERASE;
                            end
                            default: case (top2)
                                EXT_EN:   begin wen_q <= 1'b1; state_q <= ST_DONE; end
                                EXT_DIS:  begin wen_q <= 1'b0; state_q <= ST_DONE; end
                                EXT_FILL: ;
                                default:  begin
                                    state_q     <= ST_DONE;
                                    pend_q      <= 1'b1;
                                    pend_kind_q <= PG_CLEAR;
                                end
                            endcase
                        endcase
                    end else if (bit_cnt_q + 1'b1 == data_end) begin
                        state_q     <= ST_DONE;
                        pend_q      <= 1'b1;
                        pend_kind_q <= (op_q == OPC_WRITE) ? PG_WORD : PG_FILL;
                    end
                end
                ST_READ: begin
                    if (rd_left_q != '0) begin
                        do_q      <= rd_sh_q[15];
                        rd_sh_q   <= {rd_sh_q[14:0], 1'b0};
                        rd_left_q <= rd_left_q - 1'b1;
                    end else begin
                        addr_q    <= addr_inc;
                        do_q      <= rd_word[15];
                        rd_sh_q   <= {rd_word[14:0], 1'b0};
                        rd_left_q <= dw_n - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    sereep_array #(.BYTES(BYTES), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .kind(pend_kind_q),
        .addr(addr_q), .data(data_q), .wide(wide_i), .rd_addr(rd_port_addr),
        .rd_word(rd_word), .busy(busy)
    );

    // Output mux: read stream first, then armed status, else quiet.
    always_comb begin
        if (in_read) begin
            sdout_oe_o = 1'b1;
            sdout_o    = do_q;
        end else if (stat_q && sel_s) begin
            sdout_oe_o = 1'b1;
            sdout_o    = ~busy;
        end else begin
            sdout_oe_o = 1'b0;
            sdout_o    = 1'b0;
        end
    end
endmodule

// File: rtl/sereep_slave_chk.sv
// Property checker for sereep_slave, attached by bind. Observes the ports
// and the signals passed between the decoder, synchroniser and array.
module sereep_slave_chk #(
    parameter int PROG_CYCLES = 400
) (
    input logic clk,
    input logic rst_n,
    input logic sel_i,
    input logic wprot_n_i,
    input logic sdout_o,
    input logic sdout_oe_o,
    input logic sk_rise,
    input logic sel_fall,
    input logic in_read,
    input logic busy,
    input logic wen_q
);
    int low_run;
    int busy_run;

    // Counts consecutive cycles with select low, and the length of each busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= 0;
            busy_run <= 0;
        end else begin
            low_run  <= sel_i ? 0 : ((low_run < 7) ? low_run + 1 : low_run);
            busy_run <= busy ? busy_run + 1 : 0;
        end
    end

    AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run >= 5) |-> (!sdout_oe_o && !sdout_o));  // R1
    AST_DATA_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe_o |-> !sdout_o);  // R1
    AST_READ_BIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read) && !$stable(sdout_o)) |-> $past(sk_rise));  // R3
    AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q));  // R5
    AST_PROG_NEEDS_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wprot_n_i));  // R6
    AST_PROG_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_fall));  // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == PROG_CYCLES));  // R7
    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_read);  // R11
    AST_LATCH_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wen_q));  // R11
endmodule

bind sereep_slave sereep_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wprot_n_i(wprot_n_i),
    .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o), .sk_rise(sk_rise),
    .sel_fall(sel_fall), .in_read(in_read), .busy(busy), .wen_q(wen_q)
);

// File: tb/sereep_slave_tb_top.sv
// Bench for sereep_slave: drives the serial bus slowly against a 125 MHz
// clk and keeps its own byte model of the array.
module sereep_slave_tb_top;
    localparam int W16  = 16;
    localparam int PROG = 1000;
    localparam int HB   = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, wprot_n = 1'b1, wide = 1'b1;
    logic sdout, sdout_oe;
    int n_chk = 0, n_fail = 0;
    logic [7:0] model [2*W16];

    always #4 clk = ~clk;

    sereep_slave #(.WORDS16(W16), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdin_i(sdin),
        .wprot_n_i(wprot_n), .wide_i(wide), .sdout_o(sdout), .sdout_oe_o(sdout_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; returns {oe, data} as seen just before this rising edge.
    task automatic bit_io(input logic b, output logic [1:0] o);
        sdin = b;
        wait_clk(HB);
        o = {sdout_oe, sdout};
        sclk = 1'b1;
        wait_clk(HB);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic [1:0] o;
        for (int i = n - 1; i >= 0; i--) bit_io(v[i], o);
    endtask

    task automatic sel_up();
        sel = 1'b1;
        wait_clk(HB);
    endtask

    task automatic sel_down();
        sel = 1'b0;
        sdin = 1'b0;
        wait_clk(HB);
    endtask

    function automatic int aw();
        return wide ? $clog2(W16) : $clog2(W16) + 1;
    endfunction

    task automatic cmd(input logic [1:0] op, input logic [31:0] addr, input logic [15:0] data, input bit with_data);
        sel_up();
        send(1, 1);
        send({30'd0, op}, 2);
        send(addr, aw());
        if (with_data) send({16'd0, data}, wide ? 16 : 8);
        sel_down();
    endtask

    function automatic logic [15:0] exp_word(input int a);
        return wide ? {model[2*a+1], model[2*a]} : {8'h00, model[a]};
    endfunction

    task automatic read_run(input int start, input int nwords, input int lead, input string req);
        logic [1:0] s;
        logic [15:0] got;
        int dw, size;
        dw = wide ? 16 : 8;
        size = wide ? W16 : 2 * W16;
        sel_up();
        send(0, lead);
        send(1, 1);
        send(2, 2);
        send(start, aw());
        bit_io(1'b0, s);
        check({req, " R3 dummy"}, {14'd0, s}, 16'h0002);
        for (int w = 0; w < nwords; w++) begin
            got = '0;
            for (int b = 0; b < dw; b++) begin
                bit_io(1'b0, s);
                got = {got[14:0], s[0]};
            end
            check(req, got, exp_word((start + w) % size));
        end
        sel_down();
    endtask

    task automatic status_is(input string req, input logic [1:0] exp);
        sel_up();
        check(req, {14'd0, sdout_oe, sdout}, {14'd0, exp});
        sel_down();
    endtask

    task automatic fill_model(input logic [15:0] d);
        for (int i = 0; i < 2 * W16; i++) model[i] = (wide && (i % 2 == 1)) ? d[15:8] : d[7:0];
    endtask

    initial begin
        int wd;
        wd = 0;
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [1:0] s;
        for (int i = 0; i < 2 * W16; i++) model[i] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: quiet outputs after reset
        check("R1 oe", {15'd0, sdout_oe}, 16'h0000);
        check("R1 data", {15'd0, sdout}, 16'h0000);
        // R1 erased array, R2 leading zeros ignored, full sweep
        read_run(0, W16, 3, "R1 erased sweep");

        // R5: write while latch clear changes nothing, no status
        cmd(2'b01, 3, 16'h1234, 1);
        status_is("R5 no status", 2'b00);
        read_run(3, 1, 0, "R5 disabled write");

        // R2: enable with nonzero don't-care low bits
        cmd(2'b00, 4'b1101, 16'h0, 0);
        cmd(2'b01, 3, 16'hA5C3, 1);
        model[6] = 8'hC3; model[7] = 8'hA5;
        sel_up();
        check("R7 busy", {14'd0, sdout_oe, sdout}, 16'h0002);
        wait_clk(PROG + 10);
        check("R7 ready", {14'd0, sdout_oe, sdout}, 16'h0003);
        bit_io(1'b1, s);
        wait_clk(HB);
        check("R8 cleared", {15'd0, sdout_oe}, 16'h0000);
        sel_down();
        read_run(3, 1, 0, "R10 write");

        // R10: overwrite with mixed 1->0 and 0->1 bits
        cmd(2'b01, 3, 16'h3C96, 1);
        model[6] = 8'h96; model[7] = 8'h3C;
        wait_clk(PROG + 10);
        read_run(3, 1, 0, "R10 erase before write");

        // R12: byte view of word 3, byte write seen in word 0
        wide = 1'b0;
        read_run(6, 2, 0, "R12 byte view");
        cmd(2'b01, 0, 16'h0081, 1);
        model[0] = 8'h81;
        wait_clk(PROG + 10);
        wide = 1'b1;
        read_run(0, 1, 0, "R12 word view");

        // R4: sequential read with wrap in both widths
        read_run(14, 4, 0, "R4 wrap x16");
        wide = 1'b0;
        read_run(30, 4, 0, "R4 wrap x8");
        wide = 1'b1;

        // R9: single erase
        cmd(2'b11, 3, 16'h0, 0);
        model[6] = 8'hFF; model[7] = 8'hFF;
        wait_clk(PROG + 10);
        read_run(3, 1, 0, "R9 erase");

        // R10: fill-all in 16-bit mode
        cmd(2'b00, 4'b0100, 16'h12EF, 1);
        fill_model(16'h12EF);
        wait_clk(PROG + 10);
        read_run(0, W16, 0, "R10 fill x16");

        // R10/R12: fill-all in 8-bit mode
        wide = 1'b0;
        cmd(2'b00, 5'b01000, 16'h005A, 1);
        fill_model(16'h005A);
        wait_clk(PROG + 10);
        read_run(0, 2 * W16, 0, "R10 fill x8");
        wide = 1'b1;

        // R9: clear-all
        cmd(2'b00, 4'b1000, 16'h0, 0);
        fill_model(16'hFFFF);
        wait_clk(PROG + 10);
        read_run(5, W16, 0, "R9 clear-all");

        // R6: write protect
        wprot_n = 1'b0;
        cmd(2'b01, 5, 16'h0BAD, 1);
        status_is("R6 no status", 2'b00);
        wprot_n = 1'b1;
        read_run(5, 1, 0, "R6 protected");

        // R11: disable and write during busy are ignored
        cmd(2'b01, 2, 16'h7777, 1);
        model[4] = 8'h77; model[5] = 8'h77;
        cmd(2'b00, 4'b0000, 16'h0, 0);
        cmd(2'b01, 9, 16'h4444, 1);
        wait_clk(PROG + 10);
        read_run(9, 1, 0, "R11 write ignored");
        read_run(2, 1, 0, "R11 first write kept");
        cmd(2'b01, 10, 16'h2222, 1);
        model[20] = 8'h22; model[21] = 8'h22;
        wait_clk(PROG + 10);
        read_run(10, 1, 0, "R11 disable ignored");

        // R13: command cut short
        sel_up();
        send(1, 1);
        send(1, 2);
        send(8, aw());
        send(8'h55, 8);
        sel_down();
        status_is("R13 no start", 2'b00);
        read_run(8, 1, 0, "R13 aborted");

        // R5: disable blocks later writes, reads still work
        cmd(2'b00, 4'b0011, 16'h0, 0);
        cmd(2'b01, 4, 16'h1111, 1);
        wait_clk(PROG + 10);
        read_run(4, 1, 0, "R5 after disable");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule